// File: doc/BRIEF.md
# Stack pull micro-sequencer

This block sequences the pull-from-stack instructions of an 8-bit processor that has two stack pointers, here called S and U. When `start` is seen while the block is idle, it captures the program counter and both pointers. It then reads a one-byte selection mask from the program counter and advances the counter past it. One spare cycle follows. After that, every register named by a set mask bit is restored from memory through the chosen pointer.

Registers are restored from the most significant mask bit down to the least. The mask bits select the registers as follows:

- bits 7..4 select the 8-bit registers CC, A, B and DP.
- bits 3..2 select the 16-bit index registers X and Y.
- bit 1 selects the pointer that is not being used for the pull.
- bit 0 selects the program counter.

Each restored value leaves on a register-file write port, tagged with its mask bit number. The block also applies a restored program counter or pointer to its own pointer outputs. A one-cycle `done` pulse follows one closing cycle after the last register.

Top module: `stk_pull_seq`

## Requirements
- R1: While `rst` is high, and after it falls, `done`, `mem_re` and `rf_we` are 0 and `pc_o`, `s_o` and `u_o` read 0 until a pull starts.
- R2: After `start` is accepted, the next cycle drives `mem_re`=1 with `mem_addr` equal to the `pc_i` value captured at start. `pc_o` ends at that value plus one, unless mask bit 0 is set.
- R3: Registers are written on the port in descending mask-bit order, one write per set bit and none for clear bits. `rf_sel` carries the bit number: 7=CC, 6=A, 5=B, 4=DP, 3=X, 2=Y, 1=the other pointer, 0=PC.
- R4: Stack bytes are read from consecutive addresses, starting at the captured S (`use_u`=0) or U (`use_u`=1). Data returns on `mem_rdata` one cycle after `mem_re`. The pointer in use ends at its start value plus the number of bytes pulled, modulo 2^16.
- R5: Mask bits 3..0 pull two bytes, the first read forming the high byte, and are written as one 16-bit value. Mask bits 7..4 pull one byte, written zero-extended.
- R6: Mask bit 1 restores U when pulling through S, and restores S when pulling through U. The value appears on `u_o` or `s_o` respectively.
- R7: When mask bit 0 is set, `pc_o` ends at the 16-bit value pulled for it.
- R8: `done` is a one-cycle pulse, 3 + 2·(8-bit registers) + 4·(16-bit registers) cycles after the start edge. A mask of 0x00 takes 3 cycles, with no stack read and no register write.
- R9: `start` raised while a pull is in progress has no effect on the values written, the final pointers or the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pull (sampled when idle) |
| use_u | input | 1 | 0 pulls through S, 1 through U |
| pc_i | input | 16 | Program counter at start |
| s_i | input | 16 | S pointer at start |
| u_i | input | 16 | U pointer at start |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| rf_we | output | 1 | Register-file write strobe |
| rf_sel | output | 3 | Register select (mask bit number) |
| rf_data | output | 16 | Register write value |
| pc_o | output | 16 | Current program counter |
| s_o | output | 16 | Current S pointer |
| u_o | output | 16 | Current U pointer |
| done | output | 1 | End-of-instruction pulse |

## Verification
Fixed masks check the two extremes of the sequence:

- 0x00 checks that the fetch, spare and closing cycles happen with nothing pulled.
- 0xFF, through each pointer, exercises every register and both 16-bit byte orderings in one run.
- 0x02 and 0x01 on their own show whether the other-pointer restore and the program counter load hit the right register.

Random masks with random pointer and counter values, through both S and U, show whether the order of writes, the byte count and the cycle count follow the mix of 8-bit and 16-bit registers. The random runs also check pointer wrap-around. In some runs `start` is pulsed mid-pull, and the result must match the undisturbed reference exactly.

// File: rtl/stk_pull_pkg.sv
package stk_pull_pkg;

    localparam int AW    = 16;          // address / pointer width
    localparam int BW    = 8;           // memory byte width
    localparam int RW    = 2 * BW;      // widest register value
    localparam int MW    = 8;           // selection mask width
    localparam int IDXW  = $clog2(MW);
    localparam int NWIDE = 4;           // mask bits below this are 16-bit registers

    localparam logic [IDXW-1:0] IDX_PC  = IDXW'(0);
    localparam logic [IDXW-1:0] IDX_OSP = IDXW'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_GAP,
        ST_RD,
        ST_WAIT,
        ST_END
    } st_e;

    typedef struct packed {
        logic            we;
        logic [IDXW-1:0] sel;
        logic [RW-1:0]   data;
    } rf_wr_t;

    function automatic logic is_wide(input logic [IDXW-1:0] idx);
        return 32'(idx) < NWIDE;
    endfunction

    // bits strictly below idx
    function automatic logic [MW-1:0] below_mask(input logic [IDXW-1:0] idx);
        logic [MW-1:0] m;
        for (int i = 0; i < MW; i++) begin
            m[i] = (i < 32'(idx));
        end
        return m;
    endfunction

endpackage

// File: rtl/stk_pull_prio.sv
module stk_pull_prio
    import stk_pull_pkg::*;
(
    input  logic [MW-1:0]   mask_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);

    logic [IDXW-1:0] idx_chain [MW+1];

    assign idx_chain[0] = '0;

    generate
        for (genvar g = 0; g < MW; g++) begin : g_stage
            assign idx_chain[g+1] = mask_i[g] ? IDXW'(g) : idx_chain[g];
        end
    endgenerate

    assign idx_o = idx_chain[MW];
    assign any_o = |mask_i;

endmodule

// File: rtl/stk_pull_ctrl.sv
module stk_pull_ctrl
    import stk_pull_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [BW-1:0]   mem_rdata,
    input  logic [IDXW-1:0] top_idx,
    output st_e             state_o,
    output logic [MW-1:0]   mask_o,
    output logic            load_o,
    output logic            fetch_o,
    output logic            stack_rd_o,
    output rf_wr_t          wr_o,
    output logic            done_o
);

    st_e           state_q, state_n;
    logic [MW-1:0] mask_q;
    logic [BW-1:0] hi_q;
    logic          lo_phase_q;
    logic          wide;
    logic [MW-1:0] rest;

    assign wide = is_wide(top_idx);
    assign rest = mask_q & below_mask(top_idx);

    always_comb begin
        state_n = state_q;
        load_o  = 1'b0;
        wr_o    = '0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load_o  = 1'b1;
                    state_n = ST_FETCH;
                end
            end
            ST_FETCH: state_n = ST_GAP;
            ST_GAP:   state_n = (|mem_rdata) ? ST_RD : ST_END;
            ST_RD:    state_n = ST_WAIT;
            ST_WAIT: begin
                if (wide && !lo_phase_q) begin
                    state_n = ST_RD;
                end else begin
                    wr_o.we   = 1'b1;
                    wr_o.sel  = top_idx;
                    wr_o.data = wide ? {hi_q, mem_rdata}
                                     : {{(RW-BW){1'b0}}, mem_rdata};
                    state_n   = (|rest) ? ST_RD : ST_END;
                end
            end
            ST_END:   state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            mask_q     <= '0;
            hi_q       <= '0;
            lo_phase_q <= 1'b0;
        end else begin
            state_q <= state_n;
            case (state_q)
                ST_GAP: begin
                    mask_q     <= mem_rdata;
                    lo_phase_q <= 1'b0;
                end
                ST_WAIT: begin
                    if (wide && !lo_phase_q) begin
                        hi_q       <= mem_rdata;
                        lo_phase_q <= 1'b1;
                    end else begin
                        mask_q     <= rest;
                        lo_phase_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state_o    = state_q;
    assign mask_o     = mask_q;
    assign fetch_o    = (state_q == ST_FETCH);
    assign stack_rd_o = (state_q == ST_RD);
    assign done_o     = (state_q == ST_END);

endmodule

// File: rtl/stk_pull_ptrs.sv
module stk_pull_ptrs
    import stk_pull_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          use_u,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] s_i,
    input  logic [AW-1:0] u_i,
    input  logic          pc_inc,
    input  logic          sp_inc,
    input  rf_wr_t        wr,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] s_o,
    output logic [AW-1:0] u_o,
    output logic [AW-1:0] act_sp_o
);

    logic [AW-1:0] pc_q, s_q, u_q;
    logic          use_u_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            s_q     <= '0;
            u_q     <= '0;
            use_u_q <= 1'b0;
        end else if (load) begin
            pc_q    <= pc_i;
            s_q     <= s_i;
            u_q     <= u_i;
            use_u_q <= use_u;
        end else begin
            if (pc_inc) begin
                pc_q <= pc_q + AW'(1);
            end
            if (sp_inc) begin
                if (use_u_q) u_q <= u_q + AW'(1);
                else         s_q <= s_q + AW'(1);
            end
            if (wr.we && wr.sel == IDX_PC) begin
                pc_q <= wr.data[AW-1:0];
            end
            if (wr.we && wr.sel == IDX_OSP) begin
                if (use_u_q) s_q <= wr.data[AW-1:0];
                else         u_q <= wr.data[AW-1:0];
            end
        end
    end

    assign pc_o     = pc_q;
    assign s_o      = s_q;
    assign u_o      = u_q;
    assign act_sp_o = use_u_q ? u_q : s_q;

endmodule

// File: rtl/stk_pull_seq.sv
module stk_pull_seq
    import stk_pull_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            use_u,
    input  logic [AW-1:0]   pc_i,
    input  logic [AW-1:0]   s_i,
    input  logic [AW-1:0]   u_i,
    output logic            mem_re,
    output logic [AW-1:0]   mem_addr,
    input  logic [BW-1:0]   mem_rdata,
    output logic            rf_we,
    output logic [IDXW-1:0] rf_sel,
    output logic [RW-1:0]   rf_data,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   s_o,
    output logic [AW-1:0]   u_o,
    output logic            done
);

    st_e             state;
    logic [MW-1:0]   mask_q;
    logic [IDXW-1:0] top_idx;
    logic            mask_any;
    logic            load, fetch, stack_rd;
    rf_wr_t          wr;
    logic [AW-1:0]   act_sp;

    stk_pull_prio u_prio (
        .mask_i (mask_q),
        .idx_o  (top_idx),
        .any_o  (mask_any)
    );

    stk_pull_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_rdata  (mem_rdata),
        .top_idx    (top_idx),
        .state_o    (state),
        .mask_o     (mask_q),
        .load_o     (load),
        .fetch_o    (fetch),
        .stack_rd_o (stack_rd),
        .wr_o       (wr),
        .done_o     (done)
    );

    stk_pull_ptrs u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .use_u    (use_u),
        .pc_i     (pc_i),
        .s_i      (s_i),
        .u_i      (u_i),
        .pc_inc   (fetch),
        .sp_inc   (stack_rd),
        .wr       (wr),
        .pc_o     (pc_o),
        .s_o      (s_o),
        .u_o      (u_o),
        .act_sp_o (act_sp)
    );

    assign mem_re   = fetch | stack_rd;
    assign mem_addr = fetch ? pc_o : act_sp;
    assign rf_we    = wr.we;
    assign rf_sel   = wr.sel;
    assign rf_data  = wr.data;

endmodule

// File: rtl/stk_pull_chk.sv
module stk_pull_chk
    import stk_pull_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [AW-1:0]   pc_i,
    input st_e             state,
    input logic [MW-1:0]   mask_q,
    input logic [AW-1:0]   act_sp,
    input logic            mem_re,
    input logic [AW-1:0]   mem_addr,
    input logic            rf_we,
    input logic [IDXW-1:0] rf_sel,
    input logic [RW-1:0]   rf_data,
    input logic            done
);

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (mem_re && mem_addr == $past(pc_i))); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_re && state == ST_RD) |=> (act_sp == $past(act_sp) + AW'(1))); // R4

    AST_READ_SPACING: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> !mem_re); // R4

    AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> ((mask_q & ~$past(mask_q)) == '0)); // R3

    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rf_we && 32'(rf_sel) >= NWIDE) |-> (rf_data[RW-1:BW] == '0)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_re && !rf_we)); // R8

endmodule

bind stk_pull_seq stk_pull_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pc_i     (pc_i),
    .state    (state),
    .mask_q   (mask_q),
    .act_sp   (act_sp),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .rf_sel   (rf_sel),
    .rf_data  (rf_data),
    .done     (done)
);

// File: tb/stk_pull_seq_tb_top.sv
module stk_pull_seq_tb_top;
    import stk_pull_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic            use_u;
    logic [AW-1:0]   pc_i, s_i, u_i;
    logic            mem_re;
    logic [AW-1:0]   mem_addr;
    logic [BW-1:0]   mem_rdata;
    logic            rf_we;
    logic [IDXW-1:0] rf_sel;
    logic [RW-1:0]   rf_data;
    logic [AW-1:0]   pc_o, s_o, u_o;
    logic            done;

    logic [7:0] mem [65536];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    stk_pull_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .use_u(use_u),
        .pc_i(pc_i), .s_i(s_i), .u_i(u_i),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rf_we(rf_we), .rf_sel(rf_sel), .rf_data(rf_data),
        .pc_o(pc_o), .s_o(s_o), .u_o(u_o), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic run_op(input logic [7:0] pb, input bit uu,
                          input logic [15:0] pc, input logic [15:0] s,
                          input logic [15:0] u, input bit poke);
        logic [15:0] ptr, epc, es, eu, v;
        logic [2:0]  esel [8];
        logic [15:0] edat [8];
        logic [2:0]  wsel [16];
        logic [15:0] wdat [16];
        int ne, nw, ecyc, cyc, nstack;
        bit got_done;
        mem[pc] = pb;
        ptr = uu ? u : s;
        epc = pc + 16'd1; es = s; eu = u;
        ne = 0; ecyc = 3;
        for (int b = 7; b >= 0; b--) begin
            if (pb[b]) begin
                if (b >= 4) begin
                    v = {8'h00, mem[ptr]}; ptr = ptr + 16'd1; ecyc += 2;
                end else begin
                    v = {mem[ptr], mem[16'(ptr + 16'd1)]}; ptr = ptr + 16'd2; ecyc += 4;
                end
                esel[ne] = 3'(b); edat[ne] = v; ne++;
                if (b == 1) begin if (uu) es = v; else eu = v; end
                if (b == 0) epc = v;
            end
        end
        if (uu) eu = ptr; else es = ptr;

        @(negedge clk);
        use_u = uu; pc_i = pc; s_i = s; u_i = u; start = 1'b1;
        cyc = 0; nw = 0; nstack = 0; got_done = 0;
        while (!got_done && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1) begin
                start = 1'b0;
                check(mem_re && mem_addr == pc, "R2", "postbyte fetch address", int'(mem_addr), int'(pc));
            end
            if (poke && cyc == 2) start = 1'b1;
            if (poke && cyc == 3) start = 1'b0;
            if (mem_re && cyc > 1) nstack++;
            if (rf_we && nw < 16) begin
                wsel[nw] = rf_sel; wdat[nw] = rf_data; nw++;
            end
            if (done) got_done = 1;
        end
        check(got_done && cyc == ecyc, poke ? "R9" : "R8", "cycles to done", cyc, ecyc);
        check(nw == ne, "R3", "write count", nw, ne);
        for (int i = 0; i < ne && i < nw; i++) begin
            check(wsel[i] == esel[i], "R3", "write order select", int'(wsel[i]), int'(esel[i]));
            check(wdat[i] == edat[i], "R5", "register value", int'(wdat[i]), int'(edat[i]));
        end
        check(pc_o == epc, (pb[0]) ? "R7" : "R2", "final pc", int'(pc_o), int'(epc));
        check(s_o == es, (pb[1] && uu) ? "R6" : "R4", "final S", int'(s_o), int'(es));
        check(u_o == eu, (pb[1] && !uu) ? "R6" : "R4", "final U", int'(u_o), int'(eu));
        check(nstack == int'(16'(ptr - (uu ? u : s))), "R4", "stack read count",
              nstack, int'(16'(ptr - (uu ? u : s))));
        if (poke) begin
            @(negedge clk);
            check(!done && !mem_re, "R9", "no restart after mid-pull start", int'(mem_re), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0B17;
        void'($urandom(seed));
        for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
        rst = 1'b1; start = 1'b0; use_u = 1'b0;
        pc_i = '0; s_i = '0; u_i = '0;
        repeat (3) @(negedge clk);
        check(!done && !mem_re && !rf_we, "R1", "outputs in reset", int'({done, mem_re, rf_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !mem_re && !rf_we, "R1", "outputs after reset", int'({done, mem_re, rf_we}), 0);
        check(pc_o == 0 && s_o == 0 && u_o == 0, "R1", "pointers after reset",
              int'(pc_o | s_o | u_o), 0);

        run_op(8'h00, 1'b0, 16'h1000, 16'h2000, 16'h3000, 1'b0);  // R8 empty mask
        run_op(8'h00, 1'b1, 16'h1100, 16'h2100, 16'h3100, 1'b1);
        run_op(8'hFF, 1'b0, 16'h4000, 16'h5000, 16'h6000, 1'b0);
        run_op(8'hFF, 1'b1, 16'h4100, 16'h5100, 16'h6100, 1'b0);
        run_op(8'h02, 1'b0, 16'h7000, 16'h7100, 16'h7200, 1'b0);  // R6 through S
        run_op(8'h02, 1'b1, 16'h7300, 16'h7400, 16'h7500, 1'b0);  // R6 through U
        run_op(8'h01, 1'b0, 16'h7600, 16'h7700, 16'h7800, 1'b0);  // R7
        run_op(8'h88, 1'b1, 16'h7900, 16'h0010, 16'hFFFD, 1'b0);  // R4 wrap
        for (int k = 0; k < 120; k++) begin
            run_op(8'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                   16'($urandom), (k % 5) == 0);
        end
        finish_run();
    end

endmodule